// File: doc/BRIEF.md
# Core Launch Memory Loader

This block sits on the hub side of a multi-core processor and brings one core to life from shared memory. A launch command word names a target core, or asks for whichever core is idle, together with a long-aligned code address and a long-aligned parameter address. The block answers the requester one cycle later. The copy itself then runs in the background, driven by a per-core loader that belongs to the target core.

Each loader reads one long from shared RAM or ROM in every hub slot that its core owns. It writes the first 496 words of the core's private 512-word memory from consecutive shared longs. It places the 14-bit parameter field in word 496 and zeroes words 497 to 511. After the last word is written, the core is released to run from core address 0. The requester takes no further part in the load, so it may stop itself in the very next cycle without effect on the load.

When reset is released, the block loads core 0 from a fixed boot address without any command.

Top module: `core_launch_loader`

## Requirements
- R1: The command word holds the parameter long address in bits 31:18 and the code long address in bits 17:4. Bit 3 clear selects the core numbered by bits 2:0 explicitly.
- R2: `rspValid` is high for exactly the one cycle after a cycle with `cmdValid` high, and carries the result of that command.
- R3: With bit 3 set, the lowest-numbered idle core (neither busy nor running) is chosen and returned in `rspCore` with `rspNoFree` low. If no core is idle, `rspNoFree` is high, `rspCore` is 0, and no core changes state.
- R4: Core memory word n, for n from 0 to 495, receives the shared long at address (code + n) modulo 2^14.
- R5: Core word 496 receives the parameter field, zero-extended to 32 bits. Words 497 to 511 receive zero.
- R6: The target's `coreBusy` is high from the reply cycle until its final word is written. `coreRun` then rises and `coreBusy` falls. A running core executes from core address 0.
- R7: A pulse on `coreStop[i]` makes only core i idle, and aborts only core i's load. Stopping the requester right after its launch leaves the launched load intact.
- R8: Launching a core that is busy or running restarts its load from word 0 with the new addresses. No write from the abandoned load reaches the core after the reply.
- R9: After reset, core 0 is busy loading from the boot code address with parameter 0, and every other core is idle.
- R10: The hub slot advances by one core per cycle and starts at 0 after reset. A word for core i is only fetched in slot i, so each core memory write appears in the cycle after the slot of that core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Launch command present this cycle |
| cmdWord | input | 32 | Launch command word |
| rspValid | output | 1 | Reply valid |
| rspCore | output | 3 | Core chosen for the launch |
| rspNoFree | output | 1 | No idle core was available |
| coreStop | input | 8 | Per-core stop request |
| coreBusy | output | 8 | Per-core load in progress |
| coreRun | output | 8 | Per-core released to execute |
| memRd | output | 1 | Shared memory read strobe |
| memAddr | output | 14 | Shared memory long address |
| memRdData | input | 32 | Shared memory data, one cycle after `memRd` |
| coreWe | output | 1 | Core memory write enable |
| coreSel | output | 3 | Core memory being written |
| coreWAddr | output | 9 | Core memory word address |
| coreWData | output | 32 | Core memory write data |

## Verification
The assertions assume that shared memory returns the addressed long on `memRdData` exactly one cycle after `memRd`. They also assume that `cmdValid` is a pulse whose word is stable in that cycle. The bench meets both assumptions with a memory model that produces an arithmetic function of the address on the clock edge after the read, and with launch pulses of one cycle, spaced at least two cycles apart. Stop pulses are one cycle long. They are placed both right after a reply and in the middle of a load, so the checks on stop and relaunch see their real edge timing.

// File: rtl/core_launch_pkg.sv
package core_launch_pkg;
  parameter int NUM_CORES  = 8;
  parameter int CORE_WORDS = 512;
  parameter int COPY_WORDS = 496;
  parameter int ADDR_W     = 14;
  parameter int DATA_W     = 32;

  localparam int ID_W     = $clog2(NUM_CORES);
  localparam int CORE_AW  = $clog2(CORE_WORDS);
  localparam int CNT_W    = CORE_AW + 1;
  localparam int CODE_LSB = ID_W + 1;
  localparam int PAR_LSB  = CODE_LSB + ADDR_W;
  localparam int CMD_W    = PAR_LSB + ADDR_W;

  typedef struct packed {
    logic              go;
    logic [ID_W-1:0]   core;
    logic [ADDR_W-1:0] code;
    logic [ADDR_W-1:0] par;
  } launchStrobe_t;

  typedef enum logic [1:0] {CORE_IDLE, CORE_LOAD, CORE_RUN} coreState_t;
endpackage

// File: rtl/launch_ctrl.sv
module launch_ctrl
  import core_launch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_CODE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic [CMD_W-1:0]     cmdWord,
  input  logic [NUM_CORES-1:0] coreStop,
  input  logic [NUM_CORES-1:0] loadDone,
  output launchStrobe_t        strobe,
  output logic [NUM_CORES-1:0] coreBusy,
  output logic [NUM_CORES-1:0] coreRun,
  output logic                 rspValid,
  output logic [ID_W-1:0]      rspCore,
  output logic                 rspNoFree
);
  coreState_t state [NUM_CORES];

  logic            anyReq;
  logic            freeFound;
  logic [ID_W-1:0] freeIdx;
  logic [ID_W-1:0] pickCore;
  logic            pickOk;

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (state[i] == CORE_IDLE) begin
        freeFound = 1'b1;
        freeIdx   = ID_W'(i);
      end
    end
    anyReq   = cmdWord[ID_W];
    pickCore = anyReq ? freeIdx : cmdWord[ID_W-1:0];
    pickOk   = !anyReq || freeFound;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe.go   <= 1'b1;
      strobe.core <= '0;
      strobe.code <= BOOT_CODE;
      strobe.par  <= '0;
      rspValid    <= 1'b0;
      rspCore     <= '0;
      rspNoFree   <= 1'b0;
      for (int i = 0; i < NUM_CORES; i++)
        state[i] <= (i == 0) ? CORE_LOAD : CORE_IDLE;
    end else begin
      strobe.go   <= cmdValid && pickOk;
      strobe.core <= pickCore;
      strobe.code <= cmdWord[CODE_LSB +: ADDR_W];
      strobe.par  <= cmdWord[PAR_LSB +: ADDR_W];
      rspValid    <= cmdValid;
      rspCore     <= pickOk ? pickCore : '0;
      rspNoFree   <= !pickOk;
      for (int i = 0; i < NUM_CORES; i++) begin
        if (cmdValid && pickOk && pickCore == ID_W'(i))
          state[i] <= CORE_LOAD;
        else if (coreStop[i])
          state[i] <= CORE_IDLE;
        else if (state[i] == CORE_LOAD && loadDone[i])
          state[i] <= CORE_RUN;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      coreBusy[i] = (state[i] == CORE_LOAD);
      coreRun[i]  = (state[i] == CORE_RUN);
    end
  end

  // R2
  reply_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(cmdValid));

  // R3
  no_free_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspNoFree) |-> ($past(coreBusy | coreRun) == '1));

  // R6
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspNoFree) |-> coreBusy[rspCore]);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_runChk
    // R6
    run_after_done_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(coreRun[g]) |-> $past(loadDone[g]));
  end
endmodule

// File: rtl/launch_dp.sv
module launch_dp
  import core_launch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  launchStrobe_t        strobe,
  input  logic [NUM_CORES-1:0] loading,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 memRd,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 coreWe,
  output logic [ID_W-1:0]      coreSel,
  output logic [CORE_AW-1:0]   coreWAddr,
  output logic [DATA_W-1:0]    coreWData,
  output logic [NUM_CORES-1:0] loadDone
);
  localparam logic [CNT_W-1:0]   COPY_CNT  = CNT_W'(COPY_WORDS);
  localparam logic [CORE_AW-1:0] PAR_WORD  = CORE_AW'(COPY_WORDS);
  localparam logic [CORE_AW-1:0] LAST_WORD = CORE_AW'(CORE_WORDS - 1);

  logic [ID_W-1:0]   slot;
  logic [CNT_W-1:0]  cnt   [NUM_CORES];
  logic [ADDR_W-1:0] codeR [NUM_CORES];
  logic [ADDR_W-1:0] parR  [NUM_CORES];

  logic               wrValid;
  logic [ID_W-1:0]    wrCore;
  logic [CORE_AW-1:0] wrAddr;
  logic [ADDR_W-1:0]  wrPar;

  logic slotGo;
  logic issue;
  logic wrKill;

  always_comb begin
    slotGo  = strobe.go && (strobe.core == slot);
    issue   = loading[slot] && !cnt[slot][CORE_AW] && !slotGo;
    memRd   = issue && (cnt[slot] < COPY_CNT);
    memAddr = codeR[slot] + ADDR_W'(cnt[slot]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= '0;
      wrValid <= 1'b0;
      wrCore  <= '0;
      wrAddr  <= '0;
      wrPar   <= '0;
      for (int i = 0; i < NUM_CORES; i++) begin
        cnt[i]   <= '0;
        codeR[i] <= '0;
        parR[i]  <= '0;
      end
    end else begin
      slot    <= (slot == ID_W'(NUM_CORES - 1)) ? '0 : slot + 1'b1;
      wrValid <= issue;
      wrCore  <= slot;
      wrAddr  <= cnt[slot][CORE_AW-1:0];
      wrPar   <= parR[slot];
      for (int i = 0; i < NUM_CORES; i++) begin
        if (strobe.go && strobe.core == ID_W'(i)) begin
          cnt[i]   <= '0;
          codeR[i] <= strobe.code;
          parR[i]  <= strobe.par;
        end else if (issue && slot == ID_W'(i)) begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    wrKill    = strobe.go && (strobe.core == wrCore);
    coreWe    = wrValid && !wrKill;
    coreSel   = wrCore;
    coreWAddr = wrAddr;
    if (wrAddr < PAR_WORD)
      coreWData = memRdData;
    else if (wrAddr == PAR_WORD)
      coreWData = {{(DATA_W-ADDR_W){1'b0}}, wrPar};
    else
      coreWData = '0;
    for (int i = 0; i < NUM_CORES; i++)
      loadDone[i] = coreWe && (wrCore == ID_W'(i)) && (wrAddr == LAST_WORD);
  end

  // R4
  write_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (coreWe && coreWAddr < PAR_WORD) |-> $past(memRd));

  // R5
  top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (coreWe && coreWAddr > PAR_WORD) |-> (coreWData == '0));
endmodule

// File: rtl/core_launch_loader.sv
module core_launch_loader
  import core_launch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_CODE = 14'h3C01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmdValid,
  input  logic [CMD_W-1:0]     cmdWord,
  output logic                 rspValid,
  output logic [ID_W-1:0]      rspCore,
  output logic                 rspNoFree,
  input  logic [NUM_CORES-1:0] coreStop,
  output logic [NUM_CORES-1:0] coreBusy,
  output logic [NUM_CORES-1:0] coreRun,
  output logic                 memRd,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic [DATA_W-1:0]    memRdData,
  output logic                 coreWe,
  output logic [ID_W-1:0]      coreSel,
  output logic [CORE_AW-1:0]   coreWAddr,
  output logic [DATA_W-1:0]    coreWData
);
  launchStrobe_t        strobe;
  logic [NUM_CORES-1:0] loadDone;

  launch_ctrl #(.BOOT_CODE(BOOT_CODE)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdWord  (cmdWord),
    .coreStop (coreStop),
    .loadDone (loadDone),
    .strobe   (strobe),
    .coreBusy (coreBusy),
    .coreRun  (coreRun),
    .rspValid (rspValid),
    .rspCore  (rspCore),
    .rspNoFree(rspNoFree)
  );

  launch_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .loading  (coreBusy),
    .memRdData(memRdData),
    .memRd    (memRd),
    .memAddr  (memAddr),
    .coreWe   (coreWe),
    .coreSel  (coreSel),
    .coreWAddr(coreWAddr),
    .coreWData(coreWData),
    .loadDone (loadDone)
  );
endmodule

// File: tb/core_launch_loader_test.sv
module core_launch_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] BOOT = 14'h3C01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdWord = '0;
  logic        rspValid;
  logic [2:0]  rspCore;
  logic        rspNoFree;
  logic [7:0]  coreStop = '0;
  logic [7:0]  coreBusy;
  logic [7:0]  coreRun;
  logic        memRd;
  logic [13:0] memAddr;
  logic [31:0] memRdData = '0;
  logic        coreWe;
  logic [2:0]  coreSel;
  logic [8:0]  coreWAddr;
  logic [31:0] coreWData;

  int checks = 0;
  int errors = 0;

  core_launch_loader #(.BOOT_CODE(BOOT)) uut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .rspValid(rspValid), .rspCore(rspCore), .rspNoFree(rspNoFree),
    .coreStop(coreStop), .coreBusy(coreBusy), .coreRun(coreRun),
    .memRd(memRd), .memAddr(memAddr), .memRdData(memRdData),
    .coreWe(coreWe), .coreSel(coreSel), .coreWAddr(coreWAddr),
    .coreWData(coreWData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] img(input logic [13:0] a);
    return (32'h9E3779B9 * ({18'b0, a} + 32'd1)) ^ 32'h0F0F1234;
  endfunction

  // shared memory model: data one cycle after the read strobe
  always @(posedge clk) if (memRd) memRdData <= img(memAddr);

  // hub slot model
  logic [2:0] slotModel;
  always @(posedge clk) slotModel <= rst ? 3'd0 : slotModel + 3'd1;

  logic [13:0]  pendCode, pendPar;
  logic [13:0]  expCode [8];
  logic [13:0]  expPar  [8];
  logic [511:0] seen    [8];
  int           imgBad  [8];
  int           topBad  [8];
  logic [31:0]  badAct  [8];
  logic [31:0]  badExp  [8];
  int           slotBad = 0;

  always @(negedge clk) begin
    if (rst) begin
      for (int c = 0; c < 8; c++) begin
        seen[c] = '0; imgBad[c] = 0; topBad[c] = 0;
        expCode[c] = '0; expPar[c] = '0; badAct[c] = '0; badExp[c] = '0;
      end
      expCode[0] = BOOT;
    end else begin
      if (coreWe) begin
        logic [31:0] e;
        if (coreSel != slotModel - 3'd1) slotBad++;
        if (coreWAddr < 9'd496) e = img(expCode[coreSel] + {5'b0, coreWAddr});
        else if (coreWAddr == 9'd496) e = {18'b0, expPar[coreSel]};
        else e = '0;
        if (coreWData != e) begin
          if (coreWAddr < 9'd496) imgBad[coreSel]++; else topBad[coreSel]++;
          badAct[coreSel] = coreWData; badExp[coreSel] = e;
        end
        seen[coreSel][coreWAddr] = 1'b1;
      end
      if (rspValid && !rspNoFree) begin
        expCode[rspCore] = pendCode; expPar[rspCore] = pendPar;
        seen[rspCore] = '0; imgBad[rspCore] = 0; topBad[rspCore] = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [3:0] sel, input logic [13:0] code, input logic [13:0] par,
                        input logic [7:0] stopMask, output logic [2:0] gc, output logic nf);
    pendCode = code; pendPar = par;
    cmdWord  = {par, code, sel};
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    coreStop = stopMask;
    check(rspValid === 1'b1, "R2 reply in next cycle", {31'b0, rspValid}, 32'd1);
    gc = rspCore; nf = rspNoFree;
    @(negedge clk);
    coreStop = '0;
    check(rspValid === 1'b0, "R2 reply lasts one cycle", {31'b0, rspValid}, 32'd0);
  endtask

  task automatic waitRun(input int c);
    while (!coreRun[c]) @(negedge clk);
    check(coreBusy[c] === 1'b0, "R6 busy falls when run rises", {31'b0, coreBusy[c]}, 32'd0);
  endtask

  task automatic checkImage(input int c);
    check(seen[c] === '1, "R4 every core word written", $countones(seen[c]), 32'd512);
    check(imgBad[c] == 0, "R4 copied image", badAct[c], badExp[c]);
    check(topBad[c] == 0, "R5 parameter and zeroed top words", badAct[c], badExp[c]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] gc;
    logic       nf;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state: core 0 loading from boot address
    check(coreBusy === 8'h01, "R9 boot load busy", {24'b0, coreBusy}, 32'h01);
    check(coreRun === 8'h00, "R9 nothing running", {24'b0, coreRun}, 32'h00);
    check(rspValid === 1'b0, "R2 no reply after reset", {31'b0, rspValid}, 32'd0);
    waitRun(0);
    checkImage(0);

    // R7: requester (core 0) stops itself right after launching core 1
    launch(4'b1000, 14'h0100, 14'h0004, 8'h01, gc, nf);
    check(gc == 3'd1 && !nf, "R3 lowest idle core chosen", {28'b0, nf, gc}, 32'd1);
    check(coreRun[0] === 1'b0, "R7 requester stopped", {31'b0, coreRun[0]}, 32'd0);
    check(coreBusy[1] === 1'b1, "R7 target still loading", {31'b0, coreBusy[1]}, 32'd1);
    waitRun(1);
    checkImage(1);

    // R1 explicit selection sweep, with a wrapping code address on core 7
    for (int c = 2; c < 8; c++) begin
      logic [13:0] cd;
      cd = (c == 7) ? 14'h3F80 : 14'(c * 1234);
      launch({1'b0, 3'(c)}, cd, 14'(16383 - c * 77), 8'h00, gc, nf);
      check(gc == 3'(c) && !nf, "R1 explicit core number", {28'b0, nf, gc}, c);
      check(coreBusy[c] === 1'b1, "R6 busy after reply", {31'b0, coreBusy[c]}, 32'd1);
    end
    for (int c = 2; c < 8; c++) begin
      waitRun(c);
      checkImage(c);
    end

    // R3 any-free picks stopped core 0, then nothing is left
    launch(4'b1000, 14'h2222, 14'h1111, 8'h00, gc, nf);
    check(gc == 3'd0 && !nf, "R3 idle core 0 chosen", {28'b0, nf, gc}, 32'd0);
    waitRun(0);
    checkImage(0);
    launch(4'b1000, 14'h0500, 14'h0001, 8'h00, gc, nf);
    check(nf && gc == 3'd0, "R3 no free core reply", {28'b0, nf, gc}, 32'h8);
    repeat (3) @(negedge clk);
    check(coreRun === 8'hFF && coreBusy === 8'h00, "R3 no state change on full",
          {16'b0, coreRun, coreBusy}, 32'hFF00);

    // R8 relaunch a running core, then again in mid-load
    launch(4'b0011, 14'h1000, 14'h0ABC, 8'h00, gc, nf);
    check(coreBusy[3] === 1'b1 && coreRun[3] === 1'b0, "R8 running core restarts",
          {30'b0, coreBusy[3], coreRun[3]}, 32'h2);
    repeat (800) @(negedge clk);
    launch(4'b0011, 14'h3FF0, 14'h0123, 8'h00, gc, nf);
    check(coreBusy[3] === 1'b1, "R8 mid-load relaunch busy", {31'b0, coreBusy[3]}, 32'd1);
    waitRun(3);
    checkImage(3);

    // R7 stop a core in mid-load, others unaffected
    launch(4'b0101, 14'h0777, 14'h0055, 8'h00, gc, nf);
    repeat (300) @(negedge clk);
    coreStop = 8'h20;
    @(negedge clk);
    coreStop = '0;
    repeat (20) @(negedge clk);
    check(coreBusy === 8'h00 && coreRun === 8'hDF, "R7 stop hits only its core",
          {16'b0, coreRun, coreBusy}, 32'hDF00);
    launch(4'b1000, 14'h0040, 14'h3333, 8'h00, gc, nf);
    check(gc == 3'd5 && !nf, "R3 stopped core 5 reused", {28'b0, nf, gc}, 32'd5);
    waitRun(5);
    checkImage(5);

    check(slotBad == 0, "R10 writes follow the owning slot", slotBad, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule